// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address into a real page address using a small table of block translation entries. Each entry is a pair of 32-bit words: an upper word that gives the block's effective base, its length and its per-privilege valid bits, and a lower word that gives the real base and a two-bit protection code. There are two independent tables. Instruction fetches search one table, and loads and stores search the other.

A request carries an effective address, an access kind and a user/supervisor flag. The matcher compares every entry of the selected table in parallel. The entry with the lowest index that hits supplies the real page address and the permission triple. When no entry hits, the response reports a miss. The response appears one clock after the request. The tables are loaded through a plain one-word-per-cycle write port. Falling back to page tables and raising faults are left to the surrounding logic.

Top module: `blk_xlat_match`

## Requirements
- R1: After reset every entry of both tables reads as zero. Every lookup therefore misses until entries are written, and in an idle cycle all response outputs are zero.
- R2: `req_kind` is coded as 0 load, 1 store, 2 fetch and 3 reserved. Kind 2 searches the instruction table, and every other kind searches the data table.
- R3: Upper-word bit 0 enables an entry for user requests (`req_user`=1), and bit 1 enables it for supervisor requests (`req_user`=0). An entry whose bit for the current privilege is clear never hits.
- R4: The upper word holds the block effective base in bits 31:17 and the length field in bits 12:2. The match mask is 0xFFFE0000 with length bit k clearing mask bit 17+k. An entry hits when (EA & mask) equals the upper word's bits 31:17, with bits 16:0 taken as zero.
- R5: On a hit, `rsp_pa` = ((lower & mask) | (EA & ~mask)) with bits 11:0 forced to zero.
- R6: The lower-word bits 1:0 give the protection code. Code 0 gives `rsp_perm`=000, code 2 gives 111, and codes 1 and 3 give 101. The bits of `rsp_perm` are {execute, write, read}.
- R7: When several entries hit, the entry with the lowest index supplies `rsp_idx`, `rsp_pa` and `rsp_perm`. An entry that hits with code 0 still counts as a hit.
- R8: A valid response with no hit sets `rsp_miss`=1 and `rsp_hit`=0, with `rsp_pa`, `rsp_perm` and `rsp_idx` at zero.
- R9: A request presented in one cycle is answered in the next cycle with `rsp_valid`=1. A cycle without a request yields `rsp_valid`=0 in the next cycle.
- R10: A configuration write (`cfg_iset`=1 selects the instruction table, `cfg_upper`=1 selects the upper word) takes effect for requests in later cycles. A request in the same cycle as the write sees the old value, and a write to one table leaves the other table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_iset | input | 1 | 1 selects the instruction table, 0 selects the data table |
| cfg_idx | input | 2 | Entry index to write |
| cfg_upper | input | 1 | 1 writes the upper word, 0 writes the lower word |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_idx | output | 2 | Index of the winning entry |
| rsp_pa | output | 32 | Real page address |
| rsp_perm | output | 3 | {execute, write, read} permission |

## Verification
A corrupted table word, or a wrong length mask, shows up on the first lookup whose address falls into the affected block. That lookup returns the wrong hit, address or permission exactly one cycle later. A fault in table selection or in the privilege valid bits appears as a hit where a miss is due, or the reverse, on the next request of the affected kind or privilege. A fault in the priority order is visible only when two entries overlap, so the stimulus builds overlapping blocks on purpose. The stimulus also mixes writes into the same cycle as lookups, so that any early or late write timing gives a mismatch on the very next response.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_RSVD  = 2'd3
   } blkx_kind_e;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } blkx_perm_t;

   localparam int PERM_W = 3;

   // R6: two-bit protection code to permission triple
   function automatic blkx_perm_t prot_decode(input logic [1:0] code);
      blkx_perm_t p;
      unique case (code)
         2'd0:    p = '{x: 1'b0, w: 1'b0, r: 1'b0};
         2'd2:    p = '{x: 1'b1, w: 1'b1, r: 1'b1};
         default: p = '{x: 1'b1, w: 1'b0, r: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/blkx_bank.sv
module blkx_bank #(
   parameter int N_ENT = 4,
   parameter int DW    = 32,
   parameter int IDX_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_iset,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic                      wr_hi,
   input  logic [DW-1:0]             wr_data,
   input  logic                      rd_iset,
   output logic [N_ENT-1:0][DW-1:0]  rd_upper,
   output logic [N_ENT-1:0][DW-1:0]  rd_lower
);
   localparam int N_SETS = 2;

   logic [N_SETS-1:0][N_ENT-1:0][DW-1:0] up_q;
   logic [N_SETS-1:0][N_ENT-1:0][DW-1:0] lo_q;

   for (genvar s = 0; s < N_SETS; s++) begin : g_set
      for (genvar e = 0; e < N_ENT; e++) begin : g_ent
         logic sel;
         assign sel = wr_en && (wr_iset == s[0]) && (wr_idx == IDX_W'(e));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_q[s][e] <= '0;
               lo_q[s][e] <= '0;
            end else if (sel) begin
               if (wr_hi) up_q[s][e] <= wr_data;
               else       lo_q[s][e] <= wr_data;
            end
         end
      end
   end

   assign rd_upper = up_q[rd_iset];
   assign rd_lower = lo_q[rd_iset];

endmodule

// File: rtl/blkx_entry_cmp.sv
module blkx_entry_cmp
   import blkx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PG_BITS  = 12,
   parameter int BEPI_LSB = 17,
   parameter int LEN_LSB  = 2,
   parameter int LEN_W    = 11,
   parameter int VU_BIT   = 0,
   parameter int VS_BIT   = 1
) (
   input  logic [ADDR_W-1:0] upper,
   input  logic [ADDR_W-1:0] lower,
   input  logic [ADDR_W-1:0] ea,
   input  logic              user,
   output logic              hit,
   output logic [ADDR_W-1:0] pa,
   output blkx_perm_t        perm
);
   localparam logic [ADDR_W-1:0] BEPI_MASK = {ADDR_W{1'b1}} << BEPI_LSB;
   localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PG_BITS;

   logic [LEN_W-1:0]  len;
   logic [ADDR_W-1:0] len_span;
   logic [ADDR_W-1:0] mask;
   logic              en;

   assign len      = upper[LEN_LSB +: LEN_W];
   assign len_span = ADDR_W'(len) << BEPI_LSB;
   assign mask     = BEPI_MASK & ~len_span;
   assign en       = user ? upper[VU_BIT] : upper[VS_BIT];
   assign hit      = en && ((ea & mask) == (upper & BEPI_MASK));
   assign pa       = ((lower & mask) | (ea & ~mask)) & PAGE_MASK;
   assign perm     = prot_decode(lower[1:0]);

endmodule

// File: rtl/blkx_prio_pick.sv
module blkx_prio_pick
   import blkx_pkg::*;
#(
   parameter int N_ENT  = 4,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic [N_ENT-1:0]             hit_vec,
   input  logic [N_ENT-1:0][ADDR_W-1:0] pa_vec,
   input  blkx_perm_t [N_ENT-1:0]       perm_vec,
   output logic                         any,
   output logic [IDX_W-1:0]             idx,
   output logic [ADDR_W-1:0]            pa,
   output blkx_perm_t                   perm
);
   // R7: scan from the top down so the lowest hitting index is written last
   always_comb begin
      idx  = '0;
      pa   = '0;
      perm = '0;
      for (int i = N_ENT-1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            idx  = IDX_W'(i);
            pa   = pa_vec[i];
            perm = perm_vec[i];
         end
      end
   end

   assign any = |hit_vec;

endmodule

// File: rtl/blk_xlat_match.sv
module blk_xlat_match
   import blkx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int N_ENT    = 4,
   parameter int PG_BITS  = 12,
   parameter int BEPI_LSB = 17,
   parameter int LEN_LSB  = 2,
   parameter int LEN_W    = 11,
   parameter bit REG_OUT  = 1'b1,
   localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_iset,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_upper,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_ea,
   input  logic [1:0]        req_kind,
   input  logic              req_user,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic [PERM_W-1:0] rsp_perm
);
   initial begin : p_param_chk
      if (N_ENT < 1)
         $fatal(1, "blk_xlat_match: N_ENT must be at least 1");
      if (LEN_LSB + LEN_W > BEPI_LSB)
         $fatal(1, "blk_xlat_match: length field overlaps block base");
      if (BEPI_LSB + LEN_W > ADDR_W)
         $fatal(1, "blk_xlat_match: length field exceeds address width");
      if (PG_BITS > BEPI_LSB)
         $fatal(1, "blk_xlat_match: page offset wider than block granule");
      if (LEN_LSB < 2)
         $fatal(1, "blk_xlat_match: valid bits must sit below the length field");
   end

   // R2: fetches use the instruction table, all other kinds the data table
   logic is_fetch;
   assign is_fetch = (req_kind == KIND_FETCH);

   logic [N_ENT-1:0][ADDR_W-1:0] ent_up;
   logic [N_ENT-1:0][ADDR_W-1:0] ent_lo;

   blkx_bank #(.N_ENT(N_ENT), .DW(ADDR_W), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_iset  (cfg_iset),
      .wr_idx   (cfg_idx),
      .wr_hi    (cfg_upper),
      .wr_data  (cfg_wdata),
      .rd_iset  (is_fetch),
      .rd_upper (ent_up),
      .rd_lower (ent_lo)
   );

   logic [N_ENT-1:0]             hit_vec;
   logic [N_ENT-1:0][ADDR_W-1:0] pa_vec;
   blkx_perm_t [N_ENT-1:0]       perm_vec;

   for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
      blkx_entry_cmp #(
         .ADDR_W   (ADDR_W),
         .PG_BITS  (PG_BITS),
         .BEPI_LSB (BEPI_LSB),
         .LEN_LSB  (LEN_LSB),
         .LEN_W    (LEN_W),
         .VU_BIT   (0),
         .VS_BIT   (1)
      ) u_cmp (
         .upper (ent_up[e]),
         .lower (ent_lo[e]),
         .ea    (req_ea),
         .user  (req_user),
         .hit   (hit_vec[e]),
         .pa    (pa_vec[e]),
         .perm  (perm_vec[e])
      );
   end

   logic              sel_any;
   logic [IDX_W-1:0]  sel_idx;
   logic [ADDR_W-1:0] sel_pa;
   blkx_perm_t        sel_perm;

   blkx_prio_pick #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
      .hit_vec  (hit_vec),
      .pa_vec   (pa_vec),
      .perm_vec (perm_vec),
      .any      (sel_any),
      .idx      (sel_idx),
      .pa       (sel_pa),
      .perm     (sel_perm)
   );

   // R8: outputs forced to zero unless a valid request hit
   logic              nx_valid, nx_hit, nx_miss;
   logic [IDX_W-1:0]  nx_idx;
   logic [ADDR_W-1:0] nx_pa;
   logic [PERM_W-1:0] nx_perm;

   assign nx_valid = req_valid;
   assign nx_hit   = req_valid && sel_any;
   assign nx_miss  = req_valid && !sel_any;
   assign nx_idx   = nx_hit ? sel_idx : '0;
   assign nx_pa    = nx_hit ? sel_pa  : '0;
   assign nx_perm  = nx_hit ? sel_perm : '0;

   if (REG_OUT) begin : g_reg_out
      // R9: one-cycle response
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_idx   <= '0;
            rsp_pa    <= '0;
            rsp_perm  <= '0;
         end else begin
            rsp_valid <= nx_valid;
            rsp_hit   <= nx_hit;
            rsp_miss  <= nx_miss;
            rsp_idx   <= nx_idx;
            rsp_pa    <= nx_pa;
            rsp_perm  <= nx_perm;
         end
      end
   end else begin : g_comb_out
      assign rsp_valid = nx_valid;
      assign rsp_hit   = nx_hit;
      assign rsp_miss  = nx_miss;
      assign rsp_idx   = nx_idx;
      assign rsp_pa    = nx_pa;
      assign rsp_perm  = nx_perm;
   end

endmodule

// File: rtl/blkx_checker.sv
module blkx_checker #(
   parameter int ADDR_W   = 32,
   parameter int PG_BITS  = 12,
   parameter int BEPI_LSB = 17,
   parameter int IDX_W    = 2,
   parameter bit REG_OUT  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_ea,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_miss,
   input logic [IDX_W-1:0]  rsp_idx,
   input logic [ADDR_W-1:0] rsp_pa,
   input logic [2:0]        rsp_perm
);
   if (REG_OUT) begin : g_props
      a_r9_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);

      a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss);

      a_r8_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> (rsp_hit != rsp_miss));

      a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_miss |-> (rsp_pa == '0 && rsp_perm == 3'b000 && rsp_idx == '0));

      a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> (rsp_pa[PG_BITS-1:0] == '0));

      a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> (rsp_pa[BEPI_LSB-1:PG_BITS] == $past(req_ea[BEPI_LSB-1:PG_BITS])));

      a_r6_perm_legal: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> (rsp_perm == 3'b000 || rsp_perm == 3'b101 || rsp_perm == 3'b111));
   end

endmodule

bind blk_xlat_match blkx_checker #(
   .ADDR_W   (ADDR_W),
   .PG_BITS  (PG_BITS),
   .BEPI_LSB (BEPI_LSB),
   .IDX_W    (IDX_W),
   .REG_OUT  (REG_OUT)
) u_blkx_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ea    (req_ea),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .rsp_idx   (rsp_idx),
   .rsp_pa    (rsp_pa),
   .rsp_perm  (rsp_perm)
);

// File: tb/blk_xlat_match_tb_top.sv
`timescale 1ns/1ps
module blk_xlat_match_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_iset = 1'b0, cfg_upper = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0, req_user = 1'b0;
   logic [31:0] req_ea = '0;
   logic [1:0]  req_kind = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [1:0]  rsp_idx;
   logic [31:0] rsp_pa;
   logic [2:0]  rsp_perm;

   always #2.5 clk = ~clk;

   blk_xlat_match dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_iset(cfg_iset), .cfg_idx(cfg_idx),
      .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_idx(rsp_idx), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   bit    chk_en = 1'b0;
   bit    done = 1'b0;
   string cur_tag = "R1";
   string exp_tag = "R1";

   // behavioural reference state: [table 0 data / 1 instr][entry]
   logic [31:0] m_up [2][4];
   logic [31:0] m_lo [2][4];
   logic        e_valid = 0, e_hit = 0, e_miss = 0;
   logic [1:0]  e_idx = 0;
   logic [31:0] e_pa = 0;
   logic [2:0]  e_perm = 0;

   function automatic void ref_lookup(input logic [31:0] ea, input logic [1:0] kind,
                                      input logic user, output logic hit,
                                      output logic [1:0] idx, output logic [31:0] pa,
                                      output logic [2:0] perm);
      int t = (kind == 2'd2) ? 1 : 0;
      hit = 0; idx = 0; pa = 0; perm = 0;
      for (int i = 0; i < 4; i++) begin
         logic [31:0] u = m_up[t][i];
         logic [31:0] l = m_lo[t][i];
         logic [31:0] mask = 32'hFFFE0000 & ~((u & 32'h00001FFC) << 15);
         logic ok = user ? u[0] : u[1];
         if (!hit && ok && ((ea & mask) == (u & 32'hFFFE0000))) begin
            hit = 1;
            idx = 2'(i);
            pa  = ((l & mask) | (ea & ~mask)) & 32'hFFFFF000;
            case (l[1:0])
               2'd0: perm = 3'b000;
               2'd2: perm = 3'b111;
               default: perm = 3'b101;
            endcase
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid = 0; e_hit = 0; e_miss = 0; e_idx = 0; e_pa = 0; e_perm = 0;
         for (int t = 0; t < 2; t++)
            for (int i = 0; i < 4; i++) begin
               m_up[t][i] = '0; m_lo[t][i] = '0;
            end
      end else begin
         logic h; logic [1:0] ix; logic [31:0] p; logic [2:0] pm;
         ref_lookup(req_ea, req_kind, req_user, h, ix, p, pm);
         e_valid = req_valid;
         e_hit   = req_valid && h;
         e_miss  = req_valid && !h;
         e_idx   = e_hit ? ix : 2'd0;
         e_pa    = e_hit ? p : 32'd0;
         e_perm  = e_hit ? pm : 3'd0;
         // R10: write lands after the same-cycle lookup was evaluated
         if (cfg_we) begin
            if (cfg_upper) m_up[cfg_iset ? 1 : 0][cfg_idx] = cfg_wdata;
            else           m_lo[cfg_iset ? 1 : 0][cfg_idx] = cfg_wdata;
         end
      end
      exp_tag = cur_tag;
      chk_en  = 1'b1;
   end

   always @(negedge clk) begin
      if (chk_en && !done) begin
         n_vec++;
         if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_miss !== e_miss ||
             rsp_idx !== e_idx || rsp_pa !== e_pa || rsp_perm !== e_perm) begin
            n_bad++;
            $display("FAIL %s: got v%b h%b m%b idx%0d pa%08h perm%03b exp v%b h%b m%b idx%0d pa%08h perm%03b",
                     exp_tag, rsp_valid, rsp_hit, rsp_miss, rsp_idx, rsp_pa, rsp_perm,
                     e_valid, e_hit, e_miss, e_idx, e_pa, e_perm);
         end
      end
   end

   task automatic cyc(input logic we, input logic iset, input logic [1:0] idx,
                      input logic hi, input logic [31:0] d, input logic rv,
                      input logic [31:0] ea, input logic [1:0] kind, input logic user);
      @(negedge clk);
      cfg_we = we; cfg_iset = iset; cfg_idx = idx; cfg_upper = hi; cfg_wdata = d;
      req_valid = rv; req_ea = ea; req_kind = kind; req_user = user;
   endtask

   task automatic wr(input logic iset, input logic [1:0] idx, input logic hi, input logic [31:0] d);
      cyc(1, iset, idx, hi, d, 0, 32'd0, 2'd0, 0);
   endtask

   task automatic look(input logic [31:0] ea, input logic [1:0] kind, input logic user);
      cyc(0, 0, 2'd0, 0, 32'd0, 1, ea, kind, user);
   endtask

   task automatic idle();
      cyc(0, 0, 2'd0, 0, 32'd0, 0, 32'd0, 2'd0, 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      cur_tag = "R1";                    // empty tables: every lookup misses
      idle();
      look(32'h1001_2345, 2'd0, 0);
      look(32'h0000_0000, 2'd2, 1);
      idle();

      cur_tag = "R4";                    // 128 KiB data block at 0x10000000, rwx
      wr(0, 2'd0, 1, 32'h1000_0003);
      wr(0, 2'd0, 0, 32'h8000_0002);
      look(32'h1001_2345, 2'd0, 0);      // hit, pa 0x80012000
      cur_tag = "R5";
      look(32'h1001_FFFF, 2'd1, 1);
      look(32'h1002_0000, 2'd0, 0);      // just past the block: miss

      cur_tag = "R2";                    // instruction table still empty
      look(32'h1001_2345, 2'd2, 0);
      look(32'h1001_2345, 2'd3, 0);      // reserved kind uses the data table
      wr(1, 2'd1, 1, 32'h1000_0002);     // supervisor-only instruction entry
      wr(1, 2'd1, 0, 32'h4000_0001);
      look(32'h1001_2345, 2'd2, 0);      // pa 0x40012000 perm 101
      cur_tag = "R3";
      look(32'h1001_2345, 2'd2, 1);      // user fetch: miss
      cur_tag = "R10";
      look(32'h1001_2345, 2'd0, 0);      // data table untouched by instr writes

      cur_tag = "R3";                    // user-only 256 MiB block
      wr(0, 2'd2, 1, 32'h2000_1FFD);
      wr(0, 2'd2, 0, 32'hC000_0003);
      look(32'h2ABC_DEF0, 2'd0, 1);      // pa 0xCABCD000 perm 101
      look(32'h2ABC_DEF0, 2'd0, 0);      // supervisor: miss

      cur_tag = "R7";                    // overlapping entry 3, code 0
      wr(0, 2'd3, 1, 32'h1000_0003);
      wr(0, 2'd3, 0, 32'h9000_0000);
      look(32'h1000_0000, 2'd0, 0);      // entry 0 wins
      wr(0, 2'd0, 1, 32'h0000_0000);
      cur_tag = "R6";
      look(32'h1000_0000, 2'd0, 0);      // entry 3 hits, perm 000

      cur_tag = "R4";                    // length 3: 512 KiB block
      wr(0, 2'd1, 1, 32'h3000_000F);
      wr(0, 2'd1, 0, 32'h5000_0002);
      look(32'h3006_1234, 2'd1, 0);      // pa 0x50061000
      look(32'h3008_0000, 2'd1, 0);      // bit 19 set: miss

      cur_tag = "R10";                   // write and lookup in one cycle
      cyc(1, 0, 2'd1, 0, 32'h6000_0001, 1, 32'h3006_1234, 2'd0, 0);
      look(32'h3006_1234, 2'd0, 0);      // new lower word now visible

      cur_tag = "R9";
      idle(); idle();
      look(32'h3000_0000, 2'd0, 0);
      idle();

      cur_tag = "R8";                    // random mixes of writes and lookups
      for (int n = 0; n < 400; n++) begin
         logic [3:0] nib_t[4] = '{4'h1, 4'h2, 4'h3, 4'h7};
         logic [31:0] up = {nib_t[$urandom_range(0, 3)], 28'($urandom)} & 32'hFFFE_1FFF;
         logic we = ($urandom_range(0, 3) == 0);
         logic hi = $urandom_range(0, 1);
         logic [31:0] d = hi ? up : $urandom;
         logic [31:0] ea = {nib_t[$urandom_range(0, 3)], 28'($urandom)};
         cyc(we, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), hi, d,
             1'($urandom_range(0, 4) != 0), ea, 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)));
      end
      idle(); idle();
      @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule